// File: doc/BRIEF.md
# I2C Combined Transaction Engine

This engine runs a complete I2C transaction from one command. The command names a 7-bit target, a register address of zero to four bytes and a data length. From that, the engine issues the sequence of byte operations itself: START, target frame, address bytes, an optional repeated START, then the data phase and the final STOP. Bit timing and pin control stay in a byte-level master underneath. The engine asks that master for one operation at a time and waits for it to report completion.

Write data enters through a valid/ready byte port, and received data leaves through another. The engine covers three uses. A write sends the address and then the data. A register read sends the address in write mode, turns the bus around with a repeated START and receives the data. A probe is a one-byte read with no address phase, and it tells whether a target answers. Each command ends with a one-cycle result pulse that carries a 3-bit code: 0 success, 1 bad request, 2 no acknowledge, 3 arbitration lost, 4 timeout.

An optional mask parameter handles paged memories. Address bits that sit above the bytes actually sent are folded into the low bits of the target address, so such a device can be reached with a single address byte.

Top module: `i2c_txn_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. While it is high, no byte operation is requested and no result is pulsed. Each accepted command yields exactly one `res_valid` pulse.
- R2: A command with length 0, or with an address length above 4, returns code 1 on the cycle after it is accepted, and no byte operation is requested.
- R3: While `bm_busy` is high before a command starts, no operation is requested. If the bus stays busy for the idle limit, the command returns code 4 with no operation issued.
- R4: A write requests, in order: START (op 0) with frame `{chip,0}`, the address bytes as TX (op 1), the data bytes as TX in the order they arrive, and STOP (op 3).
- R5: A read with an address requests: START `{chip,0}`, the address bytes as TX, START `{chip,1}`, then one RX (op 2) per data byte, then STOP.
- R6: A read with address length 0 (including a probe, which is length 1) requests START `{chip,1}`, then the RX operations, then STOP.
- R7: Every RX request asks for an acknowledge (`bm_ack_en`=1) except the last one of the command, which asks for none.
- R8: If a START or TX completes with `bm_nack` high, no further data or address operation follows. A STOP is requested and the code is 2.
- R9: If any operation completes with `bm_arb_lost` high, a STOP follows and the code is 3.
- R10: If an operation gets no completion within the per-byte limit, a STOP follows and the code is 4.
- R11: Address bytes are sent most significant first and come from the lowest N bytes of `cmd_addr`, where N is `cmd_alen`.
- R12: When N is 1 to 3, the address bits `cmd_addr[8N+6:8N]`, masked by `OVF_MASK`, are ORed into the target address used in every frame.
- R13: Each received byte is held on `rd_data` with `rd_valid` high until `rd_ready` is seen. No further operation is requested during that time.
- R14: A command that completes with no fault returns code 0 after its STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_chip | input | 7 | 7-bit target address |
| cmd_addr | input | 32 | Register address value |
| cmd_alen | input | 3 | Address bytes to send (0 to 4 valid) |
| cmd_len | input | LEN_W | Data bytes to move |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Received byte taken |
| rd_data | output | 8 | Received byte |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 3 | Result code |
| bm_req | output | 1 | One-cycle request to the byte master |
| bm_op | output | 2 | 0 START+frame, 1 TX, 2 RX, 3 STOP |
| bm_byte | output | 8 | Frame or byte to transmit |
| bm_ack_en | output | 1 | Acknowledge the received byte |
| bm_done | input | 1 | Operation complete |
| bm_nack | input | 1 | Transmitted byte not acknowledged |
| bm_arb_lost | input | 1 | Arbitration lost during the operation |
| bm_rxbyte | input | 8 | Received byte, valid with `bm_done` |
| bm_busy | input | 1 | Bus held by another master |

## Verification
In the engine's wait state, a completion report and a fault report can land in the same cycle. `bm_done` can arrive with `bm_nack` or `bm_arb_lost` set, and it can arrive on the cycle the per-byte timer would expire. The bench's byte-master model raises the fault flags together with the done pulse on a chosen operation index. It also withholds done on a chosen operation so that the timer wins. Each case is judged on the exact operation log, which must stop at the faulted operation and then show a STOP, and on the result code. A second overlap is back-pressure on read data, where a held RX byte must block the next request. This is tested by keeping `rd_ready` low and checking that the operation log does not grow.

// File: rtl/i2c_txn_pkg.sv
`timescale 1ns/1ps
package i2c_txn_pkg;

    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_TX    = 2'd1,
        BOP_RX    = 2'd2,
        BOP_STOP  = 2'd3
    } bop_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_BADREQ  = 3'd1,
        RC_NACK    = 3'd2,
        RC_ARB     = 3'd3,
        RC_TIMEOUT = 3'd4
    } rc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_IDLE_WAIT,
        S_ISSUE,
        S_WAIT,
        S_RXOUT,
        S_STOP,
        S_STOPWAIT,
        S_DONE
    } eng_state_e;

    typedef enum logic [2:0] {
        PH_CHIP,
        PH_ADDR,
        PH_RESTART,
        PH_WDATA,
        PH_RDATA
    } eng_phase_e;

    // Target frame: address in the upper seven bits, direction in bit 0.
    function automatic logic [7:0] frame_byte(input logic [6:0] chip, input logic rnw);
        return {chip, rnw};
    endfunction

endpackage

// File: rtl/i2c_txn_timer.sv
`timescale 1ns/1ps
module i2c_txn_timer #(
    parameter int LIMIT = 1000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !expired) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Once the limit is reached it stays reached until cleared.
    p_expire_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (expired && !clr && !rst) |=> expired);

endmodule

// File: rtl/i2c_txn_addr_unit.sv
`timescale 1ns/1ps
module i2c_txn_addr_unit #(
    parameter int         ADDR_BYTES = 4,
    parameter logic [6:0] OVF_MASK   = 7'h00,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int ALEN_W = $clog2(ADDR_BYTES + 2)
) (
    input  logic [6:0]        chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic [ALEN_W-1:0] sel,
    output logic [6:0]        chip_eff,
    output logic [7:0]        sel_byte
);
    logic [7:0] lanes [ADDR_BYTES];
    logic [6:0] above;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lanes[g] = addr[8*g +: 8];
    end

    // Byte lane picked by the remaining-count index (MSB lane goes first).
    always_comb begin
        sel_byte = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (sel == ALEN_W'(i)) sel_byte = lanes[i];
        end
    end

    // Bits just above the transmitted lanes, for paged devices.
    always_comb begin
        above = 7'h00;
        for (int i = 1; i < ADDR_BYTES; i++) begin
            if (alen == ALEN_W'(i)) above = addr[8*i +: 7];
        end
    end

    assign chip_eff = (alen != '0) ? (chip | (above & OVF_MASK)) : chip;

endmodule

// File: rtl/i2c_txn_engine.sv
`timescale 1ns/1ps
module i2c_txn_engine
    import i2c_txn_pkg::*;
#(
    parameter int         ADDR_BYTES   = 4,
    parameter int         LEN_W        = 16,
    parameter int         IDLE_TIMEOUT = 100_000_000,
    parameter int         BYTE_TIMEOUT = 100_000_000,
    parameter logic [6:0] OVF_MASK     = 7'h00,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int ALEN_W = $clog2(ADDR_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_read,
    input  logic [6:0]        cmd_chip,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ALEN_W-1:0] cmd_alen,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              res_valid,
    output logic [2:0]        res_code,
    output logic              bm_req,
    output logic [1:0]        bm_op,
    output logic [7:0]        bm_byte,
    output logic              bm_ack_en,
    input  logic              bm_done,
    input  logic              bm_nack,
    input  logic              bm_arb_lost,
    input  logic [7:0]        bm_rxbyte,
    input  logic              bm_busy
);
    eng_state_e        state;
    eng_phase_e        phase;
    rc_e               code_r;
    logic              is_read;
    logic [6:0]        chip_r;
    logic [ADDR_W-1:0] addr_r;
    logic [ALEN_W-1:0] alen_r;
    logic [ALEN_W-1:0] addr_left;
    logic [LEN_W-1:0]  data_left;
    logic [7:0]        rd_data_r;

    logic [6:0]        chip_eff;
    logic [7:0]        lane_byte;
    logic              idle_exp;
    logic              byte_exp;
    logic              cmd_bad;

    bop_e              issue_op;
    logic [7:0]        issue_byte;
    logic              issue_ack;

    // ---------------- address and target folding ----------------
    i2c_txn_addr_unit #(
        .ADDR_BYTES (ADDR_BYTES),
        .OVF_MASK   (OVF_MASK)
    ) u_addr (
        .chip     (chip_r),
        .addr     (addr_r),
        .alen     (alen_r),
        .sel      (addr_left - ALEN_W'(1)),
        .chip_eff (chip_eff),
        .sel_byte (lane_byte)
    );

    // ---------------- timers ----------------
    i2c_txn_timer #(.LIMIT(IDLE_TIMEOUT)) u_idle_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != S_IDLE_WAIT),
        .en      (state == S_IDLE_WAIT),
        .expired (idle_exp)
    );

    i2c_txn_timer #(.LIMIT(BYTE_TIMEOUT)) u_byte_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (!(state == S_WAIT || state == S_STOPWAIT)),
        .en      (state == S_WAIT || state == S_STOPWAIT),
        .expired (byte_exp)
    );

    // ---------------- handshake outputs ----------------
    assign cmd_ready = (state == S_IDLE);
    assign res_valid = (state == S_DONE);
    assign res_code  = code_r;
    assign rd_valid  = (state == S_RXOUT);
    assign rd_data   = rd_data_r;
    assign wr_ready  = (state == S_ISSUE) && (phase == PH_WDATA) && wr_valid;
    assign cmd_bad   = (cmd_len == '0) || (int'(cmd_alen) > ADDR_BYTES);

    // ---------------- operation selection ----------------
    always_comb begin
        issue_op   = BOP_TX;
        issue_byte = 8'h00;
        issue_ack  = 1'b0;
        case (phase)
            PH_CHIP: begin
                issue_op   = BOP_START;
                issue_byte = frame_byte(chip_eff, is_read && (alen_r == '0));
            end
            PH_ADDR:    issue_byte = lane_byte;
            PH_RESTART: begin
                issue_op   = BOP_START;
                issue_byte = frame_byte(chip_eff, 1'b1);
            end
            PH_WDATA:   issue_byte = wr_data;
            PH_RDATA: begin
                issue_op  = BOP_RX;
                issue_ack = (data_left != LEN_W'(1));
            end
            default: ;
        endcase
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            phase     <= PH_CHIP;
            code_r    <= RC_OK;
            is_read   <= 1'b0;
            chip_r    <= '0;
            addr_r    <= '0;
            alen_r    <= '0;
            addr_left <= '0;
            data_left <= '0;
            rd_data_r <= '0;
            bm_req    <= 1'b0;
            bm_op     <= BOP_START;
            bm_byte   <= '0;
            bm_ack_en <= 1'b0;
        end else begin
            bm_req <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        is_read   <= cmd_read;
                        chip_r    <= cmd_chip;
                        addr_r    <= cmd_addr;
                        alen_r    <= cmd_alen;
                        data_left <= cmd_len;
                        if (cmd_bad) begin
                            code_r <= RC_BADREQ;
                            state  <= S_DONE;
                        end else begin
                            code_r <= RC_OK;
                            state  <= S_IDLE_WAIT;
                        end
                    end
                end
                S_IDLE_WAIT: begin
                    if (!bm_busy) begin
                        phase <= PH_CHIP;
                        state <= S_ISSUE;
                    end else if (idle_exp) begin
                        code_r <= RC_TIMEOUT;
                        state  <= S_DONE;
                    end
                end
                S_ISSUE: begin
                    if (!(phase == PH_WDATA && !wr_valid)) begin
                        bm_req    <= 1'b1;
                        bm_op     <= issue_op;
                        bm_byte   <= issue_byte;
                        bm_ack_en <= issue_ack;
                        state     <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (bm_done) begin
                        if (bm_arb_lost) begin
                            code_r <= RC_ARB;
                            state  <= S_STOP;
                        end else if (bm_nack && phase != PH_RDATA) begin
                            code_r <= RC_NACK;
                            state  <= S_STOP;
                        end else begin
                            case (phase)
                                PH_CHIP: begin
                                    state <= S_ISSUE;
                                    if (alen_r != '0) begin
                                        phase     <= PH_ADDR;
                                        addr_left <= alen_r;
                                    end else begin
                                        phase <= is_read ? PH_RDATA : PH_WDATA;
                                    end
                                end
                                PH_ADDR: begin
                                    addr_left <= addr_left - ALEN_W'(1);
                                    state     <= S_ISSUE;
                                    if (addr_left == ALEN_W'(1))
                                        phase <= is_read ? PH_RESTART : PH_WDATA;
                                end
                                PH_RESTART: begin
                                    phase <= PH_RDATA;
                                    state <= S_ISSUE;
                                end
                                PH_WDATA: begin
                                    data_left <= data_left - LEN_W'(1);
                                    state <= (data_left == LEN_W'(1)) ? S_STOP : S_ISSUE;
                                end
                                PH_RDATA: begin
                                    rd_data_r <= bm_rxbyte;
                                    state     <= S_RXOUT;
                                end
                                default: state <= S_STOP;
                            endcase
                        end
                    end else if (byte_exp) begin
                        code_r <= RC_TIMEOUT;
                        state  <= S_STOP;
                    end
                end
                S_RXOUT: begin
                    if (rd_ready) begin
                        data_left <= data_left - LEN_W'(1);
                        state <= (data_left == LEN_W'(1)) ? S_STOP : S_ISSUE;
                    end
                end
                S_STOP: begin
                    bm_req    <= 1'b1;
                    bm_op     <= BOP_STOP;
                    bm_byte   <= 8'h00;
                    bm_ack_en <= 1'b0;
                    state     <= S_STOPWAIT;
                end
                S_STOPWAIT: begin
                    if (bm_done) begin
                        state <= S_DONE;
                    end else if (byte_exp) begin
                        if (code_r == RC_OK) code_r <= RC_TIMEOUT;
                        state <= S_DONE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!bm_req && !res_valid));

    p_req_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        bm_req |=> !bm_req);

    p_bad_req_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_bad) |=> (res_valid && res_code == RC_BADREQ && !bm_req));

    p_no_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE_WAIT && bm_busy) |=> !bm_req);

    p_rx_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_rx_no_req_r13: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !bm_req);

    p_code_range_r14: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_code <= 3'd4));

endmodule

// File: tb/i2c_txn_engine_tb.sv
`timescale 1ns/1ps
module i2c_txn_engine_tb;

    typedef struct packed {
        logic        rd;
        logic [6:0]  chip;
        logic [31:0] addr;
        logic [2:0]  alen;
        logic [7:0]  len;
        logic [1:0]  fk;    // 0 none, 1 nack, 2 arbitration, 3 hang
        logic [4:0]  fat;   // operation index of the fault
        logic [2:0]  code;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h50, 32'h0000_0012, 3'd2, 8'd3, 2'd0, 5'd0, 3'd0}, // R4 R11 R14
        '{1'b1, 7'h50, 32'h0000_00AB, 3'd1, 8'd4, 2'd0, 5'd0, 3'd0}, // R5 R7 R13
        '{1'b1, 7'h3C, 32'h0000_0000, 3'd0, 8'd1, 2'd0, 5'd0, 3'd0}, // R6 probe
        '{1'b1, 7'h3C, 32'h0000_0000, 3'd0, 8'd1, 2'd1, 5'd0, 3'd2}, // R8 probe NACK
        '{1'b0, 7'h2A, 32'h1122_3344, 3'd4, 8'd2, 2'd0, 5'd0, 3'd0}, // R11 four bytes
        '{1'b1, 7'h50, 32'h0000_0102, 3'd2, 8'd2, 2'd1, 5'd1, 3'd2}, // R8 NACK on address
        '{1'b0, 7'h50, 32'h0000_0007, 3'd1, 8'd2, 2'd2, 5'd2, 3'd3}, // R9
        '{1'b1, 7'h50, 32'h0000_0010, 3'd1, 8'd2, 2'd3, 5'd3, 3'd4}, // R10 hang on RX
        '{1'b0, 7'h50, 32'h0000_0345, 3'd1, 8'd1, 2'd0, 5'd0, 3'd0}, // R12 fold
        '{1'b0, 7'h50, 32'h0000_0000, 3'd1, 8'd0, 2'd0, 5'd0, 3'd1}, // R2 len 0
        '{1'b1, 7'h50, 32'h0000_0000, 3'd5, 8'd1, 2'd0, 5'd0, 3'd1}, // R2 alen 5
        '{1'b0, 7'h21, 32'h00AB_CDEF, 3'd3, 8'd1, 2'd1, 5'd4, 3'd2}, // R8 NACK on data
        '{1'b1, 7'h68, 32'h0000_0000, 3'd0, 8'd3, 2'd0, 5'd0, 3'd0}  // R6 R7 stream
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_read = 1'b0;
    logic [6:0]  cmd_chip = '0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_alen = '0;
    logic [7:0]  cmd_len = '0;
    logic        wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic        rd_ready;
    logic [7:0]  rd_data;
    logic        res_valid;
    logic [2:0]  res_code;
    logic        bm_req;
    logic [1:0]  bm_op;
    logic [7:0]  bm_byte;
    logic        bm_ack_en;
    logic        bm_done = 1'b0;
    logic        bm_nack = 1'b0;
    logic        bm_arb_lost = 1'b0;
    logic [7:0]  bm_rxbyte = '0;
    logic        bm_busy = 1'b0;

    i2c_txn_engine #(
        .ADDR_BYTES   (4),
        .LEN_W        (8),
        .IDLE_TIMEOUT (50),
        .BYTE_TIMEOUT (40),
        .OVF_MASK     (7'h07)
    ) u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_chip(cmd_chip), .cmd_addr(cmd_addr), .cmd_alen(cmd_alen), .cmd_len(cmd_len),
        .wr_valid(1'b1), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .res_valid(res_valid), .res_code(res_code),
        .bm_req(bm_req), .bm_op(bm_op), .bm_byte(bm_byte), .bm_ack_en(bm_ack_en),
        .bm_done(bm_done), .bm_nack(bm_nack), .bm_arb_lost(bm_arb_lost),
        .bm_rxbyte(bm_rxbyte), .bm_busy(bm_busy)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- byte-master model and logs ----------------
    logic       clr_logs = 1'b0;
    logic [1:0] fk = '0;
    int         fat = 0;
    int         log_n = 0;
    logic [1:0] log_op   [32];
    logic [7:0] log_byte [32];
    logic       log_ack  [32];
    int         pend = 0;
    int         pend_idx = 0;
    logic       pend_rx = 1'b0;
    int         rxc = 0;
    int         wcnt = 0;
    int         rx_n = 0;
    logic [7:0] rx_got [32];
    logic       rd_hold = 1'b0;
    int         tick = 0;

    assign wr_data  = 8'hA0 + 8'(wcnt);
    assign rd_ready = !rd_hold && (tick % 3 != 0);

    always @(negedge clk) tick <= tick + 1;

    always @(posedge clk) begin
        bm_done     <= 1'b0;
        bm_nack     <= 1'b0;
        bm_arb_lost <= 1'b0;
        if (clr_logs) begin
            log_n <= 0; rxc <= 0; wcnt <= 0; rx_n <= 0; pend <= 0;
        end else begin
            if (wr_ready) wcnt <= wcnt + 1;
            if (rd_valid && rd_ready) begin
                rx_got[rx_n] <= rd_data;
                rx_n <= rx_n + 1;
            end
            if (bm_req) begin
                if (log_n < 32) begin
                    log_op[log_n]   <= bm_op;
                    log_byte[log_n] <= bm_byte;
                    log_ack[log_n]  <= bm_ack_en;
                end
                log_n <= log_n + 1;
                if (!(fk == 2'd3 && log_n == fat)) begin
                    pend     <= 2;
                    pend_idx <= log_n;
                    pend_rx  <= (bm_op == 2'd2);
                end
            end else if (pend == 1) begin
                pend        <= 0;
                bm_done     <= 1'b1;
                bm_nack     <= (fk == 2'd1 && pend_idx == fat);
                bm_arb_lost <= (fk == 2'd2 && pend_idx == fat);
                bm_rxbyte   <= 8'h50 + 8'(rxc);
                if (pend_rx) rxc <= rxc + 1;
            end else if (pend > 1) begin
                pend <= pend - 1;
            end
        end
    end

    // ---------------- expected sequence ----------------
    int         exp_n;
    int         exp_rx;
    logic [1:0] exp_op   [32];
    logic [7:0] exp_byte [32];
    logic       exp_ack  [32];

    task automatic push(input logic [1:0] op, input logic [7:0] b, input logic a);
        exp_op[exp_n] = op; exp_byte[exp_n] = b; exp_ack[exp_n] = a;
        exp_n++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [6:0] ch;
        exp_n = 0;
        exp_rx = 0;
        if (v.len == 0 || v.alen > 3'd4) return;
        ch = v.chip;
        if (v.alen > 0 && v.alen < 4) ch = ch | (7'(v.addr >> (8 * v.alen)) & 7'h07);
        push(2'd0, {ch, v.rd && v.alen == 0}, 1'b0);
        for (int i = int'(v.alen) - 1; i >= 0; i--) push(2'd1, 8'(v.addr >> (8 * i)), 1'b0);
        if (v.rd) begin
            if (v.alen > 0) push(2'd0, {ch, 1'b1}, 1'b0);
            for (int i = 0; i < int'(v.len); i++) push(2'd2, 8'h00, i != int'(v.len) - 1);
        end else begin
            for (int i = 0; i < int'(v.len); i++) push(2'd1, 8'hA0 + 8'(i), 1'b0);
        end
        if (v.fk != 0 && int'(v.fat) < exp_n) exp_n = int'(v.fat) + 1;
        for (int i = 0; i < exp_n; i++) if (exp_op[i] == 2'd2) exp_rx++;
        if (v.fk != 0 && exp_op[exp_n-1] == 2'd2) exp_rx--;
        push(2'd3, 8'h00, 1'b0);
    endtask

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk); clr_logs = 1'b1;
        @(negedge clk); clr_logs = 1'b0;
    endtask

    task automatic run_cmd(input vec_t v, output logic [2:0] code, output bit got);
        fk = v.fk; fat = int'(v.fat);
        clear_logs();
        cmd_read = v.rd; cmd_chip = v.chip; cmd_addr = v.addr;
        cmd_alen = v.alen; cmd_len = v.len; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        got = 1'b0; code = 3'd7;
        for (int c = 0; c < 3000 && !got; c++) begin
            if (res_valid) begin got = 1'b1; code = res_code; end
            else @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_vec(input int k, input vec_t v, input logic [2:0] code, input bit got,
                             input string tag);
        bit same;
        check(got, $sformatf("%s vec %0d result pulse (R1)", tag, k), got, 1);
        check(code == v.code, $sformatf("%s vec %0d result code", tag, k), code, v.code);
        build_exp(v);
        same = (log_n == exp_n);
        for (int i = 0; i < exp_n && same; i++)
            same = (log_op[i] == exp_op[i]) &&
                   (log_op[i] == 2'd2 ? log_ack[i] == exp_ack[i] : log_byte[i] == exp_byte[i]);
        check(same, $sformatf("%s vec %0d op sequence (count shown)", tag, k), log_n, exp_n);
        same = (rx_n == exp_rx);
        for (int i = 0; i < exp_rx && same; i++) same = (rx_got[i] == 8'h50 + 8'(i));
        check(same, $sformatf("%s vec %0d read data (R13, count shown)", tag, k), rx_n, exp_rx);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [2:0] code;
        bit got;
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(cmd_ready && !res_valid && !bm_req && !rd_valid, "R1 reset state", 0, 1);

        // Table walk: R4 R5 R6 R7 R8 R9 R10 R11 R12 R14 and R2
        for (int k = 0; k < NV; k++) begin
            run_cmd(VECS[k], code, got);
            check_vec(k, VECS[k], code, got, "table");
        end

        // R3: short busy period, then the command proceeds
        v = '{1'b1, 7'h3C, 32'h0, 3'd0, 8'd1, 2'd0, 5'd0, 3'd0};
        fk = 2'd0;
        clear_logs();
        bm_busy = 1'b1;
        cmd_read = v.rd; cmd_chip = v.chip; cmd_addr = v.addr;
        cmd_alen = v.alen; cmd_len = v.len; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(log_n == 0, "R3 no operation while bus busy", log_n, 0);
        bm_busy = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 3000 && !got; c++) begin
            if (res_valid) begin got = 1'b1; code = res_code; end
            else @(negedge clk);
        end
        @(negedge clk);
        check_vec(100, v, code, got, "R3 short busy");

        // R3: bus stays busy past the idle limit
        clear_logs();
        bm_busy = 1'b1;
        cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 3000 && !got; c++) begin
            if (res_valid) begin got = 1'b1; code = res_code; end
            else @(negedge clk);
        end
        @(negedge clk);
        bm_busy = 1'b0;
        check(got && code == 3'd4, "R3 idle timeout code", code, 4);
        check(log_n == 0, "R3 idle timeout issues nothing", log_n, 0);

        // R13: read byte held while rd_ready stays low
        v = '{1'b1, 7'h68, 32'h0, 3'd0, 8'd2, 2'd0, 5'd0, 3'd0};
        fk = 2'd0;
        clear_logs();
        rd_hold = 1'b1;
        cmd_read = v.rd; cmd_chip = v.chip; cmd_addr = v.addr;
        cmd_alen = v.alen; cmd_len = v.len; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        for (int c = 0; c < 200 && !rd_valid; c++) @(negedge clk);
        repeat (30) @(negedge clk);
        check(rd_valid && rd_data == 8'h50, "R13 byte held", rd_data, 8'h50);
        check(log_n == 2, "R13 no request while held", log_n, 2);
        rd_hold = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 3000 && !got; c++) begin
            if (res_valid) begin got = 1'b1; code = res_code; end
            else @(negedge clk);
        end
        @(negedge clk);
        check_vec(101, v, code, got, "R13 release");

        // R1: idle again afterwards
        check(cmd_ready && !res_valid, "R1 idle after command", cmd_ready, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule